// File: doc/BRIEF.md
# Barrett Modular Multiplier

This block is a pipelined arithmetic unit for residues modulo an odd prime `q`. Each accepted request carries two residues `a` and `b` (both below `q`), the modulus, its bit length, a precomputed reduction constant and an operation code. The unit returns `(a*b) mod q`, `(a+b) mod q` or `(a-b) mod q`. It accepts one request per clock while the consumer keeps up.

Multiplication uses a Barrett-style reduction with an extra two bits of precision. The product `x = a*b` is shifted right by `m-2` and multiplied by `mu = floor(2^(2m+1)/q)`. That product is shifted right by `m+3` to give a quotient estimate. The estimate is never more than one short, so a single conditional subtraction of `q` finishes the reduction, and moduli up to `W-2` bits are allowed. Addition and subtraction reuse that same final correction. Addition feeds in `a+b`, and subtraction feeds in `a-b+q`, which equals subtracting and adding `q` back when the difference is negative. The caller computes the constant; the unit never divides.

The pipeline has three registered stages: operand product, quotient estimate, then remainder and correction. Both sides use a valid/ready handshake. When the output is stalled, the whole pipeline freezes.

Top module: `barrett_modmul`

## Requirements
- R1: With operation code 0, for `3 <= q`, `m = floor(log2 q)+1`, `2 <= m <= W-2`, `mu = floor(2^(2m+1)/q)` and `a, b < q`, the result equals `(a*b) mod q`.
- R2: Every result is below the modulus of its request, and the remainder before the final correction is always below `2q`, so one conditional subtraction suffices.
- R3: With operation code 1 the result equals `(a+b) mod q`.
- R4: With operation code 2 the result equals `(a-b) mod q`, taken in the range `0..q-1`.
- R5: Operation code 3 behaves exactly like code 0 (multiplication).
- R6: A request is accepted on a rising edge where `in_valid_i` and `in_ready_o` are both high. With `out_ready_i` held high, its result is shown with `out_valid_o` high after the second rising edge that follows the accepting edge.
- R7: While `out_valid_o` is high and `out_ready_i` is low, the result and `out_valid_o` hold steady and `in_ready_o` is low.
- R8: Whenever the block is out of reset and `out_ready_i` is high, `in_ready_o` is high, so back-to-back requests give one result per clock.
- R9: While `rst_ni` is low, and until the internally synchronised reset is released, `out_valid_o` and `in_ready_o` are low. Requests that were in flight when reset was asserted are discarded.
- R10: For `a = 994674970`, `b = 994705408` and `q = 994705409` with code 0, the result is 30439.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid_i | input | 1 | Request present |
| in_ready_o | output | 1 | Request can be taken this cycle |
| op_i | input | 2 | 0 multiply, 1 add, 2 subtract, 3 multiply |
| a_i | input | W | First residue, below `q` |
| b_i | input | W | Second residue, below `q` |
| q_i | input | W | Odd prime modulus |
| qlen_i | input | $clog2(W+1) | Bit length `m` of the modulus |
| mu_i | input | W | Reduction constant `floor(2^(2m+1)/q)` |
| out_valid_o | output | 1 | Result present |
| out_ready_i | input | 1 | Consumer takes the result this cycle |
| res_o | output | W | Reduced result |

## Verification
Some properties are checked by assertions on every clock. These are: the pre-correction remainder stays below twice the modulus, every presented result is below its modulus, a stalled result holds still, ready follows the output side, and the two-edge latency holds with no stall. Numeric correctness cannot be seen by a property without a reference model, so the bench scenarios show it. They cover each operation code against an independent `%` reference over 28-, 29- and 30-bit primes, the smallest modulus, the wrap cases of addition and subtraction, and the regression vector. The bench also drops requests with a reset in the middle of a stream and checks that nothing in flight comes out afterwards.

// File: rtl/bmm_pkg.sv
package bmm_pkg;

  typedef enum logic [1:0] {
    OP_MUL  = 2'd0,
    OP_ADD  = 2'd1,
    OP_SUB  = 2'd2,
    OP_MULX = 2'd3
  } bmm_op_e;

endpackage

// File: rtl/bmm_rst_sync.sv
module bmm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];

endmodule

// File: rtl/bmm_prod_stage.sv
// Stage 1: full-width product for multiplication, raw sum or offset
// difference for the additive operations.
module bmm_prod_stage
  import bmm_pkg::*;
#(
  parameter  int W  = 32,
  localparam int MW = $clog2(W+1),
  localparam int DW = 2*W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  q_i,
  input  logic [MW-1:0] m_i,
  input  logic [W-1:0]  mu_i,
  output logic          valid_o,
  output logic [DW-1:0] x_o,
  output logic [W-1:0]  q_o,
  output logic [MW-1:0] m_o,
  output logic [W-1:0]  mu_o,
  output logic          red_o
);

  logic [DW-1:0] x_d;
  logic          red_d;
  logic          load;

  always_comb begin
    unique case (bmm_op_e'(op_i))
      OP_ADD: begin
        x_d   = DW'(a_i + b_i);
        red_d = 1'b0;
      end
      OP_SUB: begin
        x_d   = DW'(a_i - b_i + q_i);
        red_d = 1'b0;
      end
      default: begin
        x_d   = DW'(a_i) * DW'(b_i);
        red_d = 1'b1;
      end
    endcase
  end

  assign load = en_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_o <= 1'b0;
    else if (en_i) valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      x_o   <= x_d;
      q_o   <= q_i;
      m_o   <= m_i;
      mu_o  <= mu_i;
      red_o <= red_d;
    end
  end

endmodule

// File: rtl/bmm_quot_stage.sv
// Stage 2: quotient estimate ((x >> (m-2)) * mu) >> (m+3).
module bmm_quot_stage #(
  parameter  int W  = 32,
  localparam int MW = $clog2(W+1),
  localparam int DW = 2*W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          valid_i,
  input  logic [DW-1:0] x_i,
  input  logic [W-1:0]  q_i,
  input  logic [MW-1:0] m_i,
  input  logic [W-1:0]  mu_i,
  input  logic          red_i,
  output logic          valid_o,
  output logic [W-1:0]  xlo_o,
  output logic [W-1:0]  q_o,
  output logic [W-1:0]  quot_o
);

  logic [MW-1:0] pre_sh;
  logic [MW-1:0] post_sh;
  logic [W-1:0]  c_w;
  logic [DW-1:0] est;
  logic [W-1:0]  quot_d;
  logic          load;

  always_comb begin
    pre_sh  = m_i - MW'(2);
    post_sh = m_i + MW'(3);
    c_w     = W'(x_i >> pre_sh);
    est     = DW'(c_w) * DW'(mu_i);
    quot_d  = red_i ? W'(est >> post_sh) : '0;
  end

  assign load = en_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_o <= 1'b0;
    else if (en_i) valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      xlo_o  <= x_i[W-1:0];
      q_o    <= q_i;
      quot_o <= quot_d;
    end
  end

endmodule

// File: rtl/bmm_corr_stage.sv
// Stage 3: remainder and the single shared conditional subtraction.
module bmm_corr_stage #(
  parameter  int W  = 32,
  localparam int DW = 2*W
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic         valid_i,
  input  logic [W-1:0] xlo_i,
  input  logic [W-1:0] q_i,
  input  logic [W-1:0] quot_i,
  output logic [W-1:0] raw_o,
  output logic         valid_o,
  output logic [W-1:0] res_o,
  output logic [W-1:0] q_o
);

  logic [DW-1:0] qq;
  logic [W-1:0]  fixed;
  logic          load;

  always_comb begin
    qq    = DW'(quot_i) * DW'(q_i);
    raw_o = xlo_i - qq[W-1:0];
    fixed = (raw_o >= q_i) ? (raw_o - q_i) : raw_o;
  end

  assign load = en_i && valid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   valid_o <= 1'b0;
    else if (en_i) valid_o <= valid_i;
  end

  always_ff @(posedge clk_i) begin
    if (load) begin
      res_o <= fixed;
      q_o   <= q_i;
    end
  end

endmodule

// File: rtl/barrett_modmul.sv
module barrett_modmul #(
  parameter  int W    = 32,
  parameter  int SYNC = 2,
  localparam int MW   = $clog2(W+1),
  localparam int DW   = 2*W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic [1:0]    op_i,
  input  logic [W-1:0]  a_i,
  input  logic [W-1:0]  b_i,
  input  logic [W-1:0]  q_i,
  input  logic [MW-1:0] qlen_i,
  input  logic [W-1:0]  mu_i,
  output logic          out_valid_o,
  input  logic          out_ready_i,
  output logic [W-1:0]  res_o
);

  logic          rst_n_s;
  logic          adv;
  logic          accept;

  logic          s1_v;
  logic [DW-1:0] s1_x;
  logic [W-1:0]  s1_q;
  logic [MW-1:0] s1_m;
  logic [W-1:0]  s1_mu;
  logic          s1_red;

  logic          s2_v;
  logic [W-1:0]  s2_x;
  logic [W-1:0]  s2_q;
  logic [W-1:0]  s2_quot;

  logic [W-1:0]  raw_rem;
  logic          s3_v;
  logic [W-1:0]  s3_q;

  bmm_rst_sync #(.STAGES(SYNC)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_s)
  );

  always_comb begin
    adv        = !(s3_v && !out_ready_i);
    in_ready_o = rst_n_s && adv;
    accept     = in_valid_i && in_ready_o;
  end

  bmm_prod_stage #(.W(W)) i_prod (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .en_i    (adv),
    .valid_i (accept),
    .op_i    (op_i),
    .a_i     (a_i),
    .b_i     (b_i),
    .q_i     (q_i),
    .m_i     (qlen_i),
    .mu_i    (mu_i),
    .valid_o (s1_v),
    .x_o     (s1_x),
    .q_o     (s1_q),
    .m_o     (s1_m),
    .mu_o    (s1_mu),
    .red_o   (s1_red)
  );

  bmm_quot_stage #(.W(W)) i_quot (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .en_i    (adv),
    .valid_i (s1_v),
    .x_i     (s1_x),
    .q_i     (s1_q),
    .m_i     (s1_m),
    .mu_i    (s1_mu),
    .red_i   (s1_red),
    .valid_o (s2_v),
    .xlo_o   (s2_x),
    .q_o     (s2_q),
    .quot_o  (s2_quot)
  );

  bmm_corr_stage #(.W(W)) i_corr (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .en_i    (adv),
    .valid_i (s2_v),
    .xlo_i   (s2_x),
    .q_i     (s2_q),
    .quot_i  (s2_quot),
    .raw_o   (raw_rem),
    .valid_o (s3_v),
    .res_o   (res_o),
    .q_o     (s3_q)
  );

  assign out_valid_o = s3_v;

endmodule

// File: rtl/bmm_checker.sv
module bmm_checker #(
  parameter int W = 32
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         rst_sync_ni,
  input logic         in_valid_i,
  input logic         in_ready_i,
  input logic         out_valid_i,
  input logic         out_ready_i,
  input logic [W-1:0] res_i,
  input logic [W-1:0] res_q_i,
  input logic         raw_valid_i,
  input logic [W-1:0] raw_i,
  input logic [W-1:0] raw_q_i
);

  // R2: remainder entering the correction is below 2q
  p_single_corr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    raw_valid_i |-> ({1'b0, raw_i} < {raw_q_i, 1'b0}));

  // R2: presented result is below its modulus
  p_res_below_q_r2: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    out_valid_i |-> (res_i < res_q_i));

  // R7: stalled output holds
  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    (out_valid_i && !out_ready_i) |=> (out_valid_i && $stable(res_i)));

  // R7: no intake while stalled
  p_stall_blocks_r7: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    (out_valid_i && !out_ready_i) |-> !in_ready_i);

  // R8: consumer ready implies intake ready
  p_full_rate_r8: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    out_ready_i |-> in_ready_i);

  // R6: two edges from acceptance to a valid output when not stalled
  p_latency_r6: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    (in_valid_i && in_ready_i) ##1 out_ready_i ##1 out_ready_i |=> out_valid_i);

  // R9: nothing presented right after reset release
  p_clean_release_r9: assert property (@(posedge clk_i) disable iff (!rst_ni || !rst_sync_ni)
    $rose(rst_sync_ni) |-> !out_valid_i);

endmodule

bind barrett_modmul bmm_checker #(.W(W)) i_bmm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rst_sync_ni (rst_n_s),
  .in_valid_i  (in_valid_i),
  .in_ready_i  (in_ready_o),
  .out_valid_i (out_valid_o),
  .out_ready_i (out_ready_i),
  .res_i       (res_o),
  .res_q_i     (s3_q),
  .raw_valid_i (s2_v),
  .raw_i       (raw_rem),
  .raw_q_i     (s2_q)
);

// File: tb/test_barrett_modmul.sv
module test_barrett_modmul;

  localparam int W      = 32;
  localparam int MW     = $clog2(W+1);
  localparam int CLK_NS = 10;
  localparam int NTBL   = 12;
  localparam int NRND   = 300;

  // {op, a, b, q, expected}
  localparam logic [129:0] TBL [NTBL] = '{
    {2'd0, 32'd994674970,  32'd994705408,  32'd994705409,  32'd30439},
    {2'd0, 32'd16,         32'd16,         32'd17,         32'd1},
    {2'd0, 32'd2,          32'd2,          32'd3,          32'd1},
    {2'd1, 32'd16,         32'd16,         32'd17,         32'd15},
    {2'd1, 32'd3,          32'd4,          32'd17,         32'd7},
    {2'd2, 32'd3,          32'd4,          32'd17,         32'd16},
    {2'd2, 32'd5,          32'd5,          32'd17,         32'd0},
    {2'd2, 32'd0,          32'd268435398,  32'd268435399,  32'd1},
    {2'd1, 32'd1073741788, 32'd1073741788, 32'd1073741789, 32'd1073741787},
    {2'd0, 32'd1073741788, 32'd1073741788, 32'd1073741789, 32'd1},
    {2'd3, 32'd5,          32'd7,          32'd17,         32'd1},
    {2'd0, 32'd0,          32'd12345,      32'd536870909,  32'd0}
  };

  logic          clk = 1'b0;
  logic          rst_ni;
  logic          in_valid_i;
  logic          in_ready_o;
  logic [1:0]    op_i;
  logic [W-1:0]  a_i, b_i, q_i, mu_i;
  logic [MW-1:0] qlen_i;
  logic          out_valid_o;
  logic          out_ready_i;
  logic [W-1:0]  res_o;

  always #(CLK_NS/2) clk = ~clk;

  barrett_modmul #(.W(W)) i_barrett_modmul (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .in_valid_i  (in_valid_i),
    .in_ready_o  (in_ready_o),
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .q_i         (q_i),
    .qlen_i      (qlen_i),
    .mu_i        (mu_i),
    .out_valid_o (out_valid_o),
    .out_ready_i (out_ready_i),
    .res_o       (res_o)
  );

  int n_chk  = 0;
  int n_fail = 0;

  logic [W-1:0] exp_q [$];
  logic [W-1:0] mod_q [$];
  string        tag_q [$];
  logic [W-1:0] cur_exp;
  string        cur_tag;

  function automatic int m_of(longint unsigned q);
    return $clog2(q + 1);
  endfunction

  function automatic logic [W-1:0] mu_of(longint unsigned q);
    longint unsigned num;
    num = 64'd1 << (2 * m_of(q) + 1);
    return W'(num / q);
  endfunction

  function automatic logic [W-1:0] ref_of(int op, longint unsigned a, longint unsigned b,
                                          longint unsigned q);
    case (op)
      1:       return W'((a + b) % q);
      2:       return W'((a + q - b) % q);
      default: return W'((a * b) % q);
    endcase
  endfunction

  task automatic check(bit ok, string req, longint unsigned act, longint unsigned expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic put(int op, longint unsigned a, longint unsigned b, longint unsigned q);
    op_i    = 2'(op);
    a_i     = W'(a);
    b_i     = W'(b);
    q_i     = W'(q);
    qlen_i  = MW'(m_of(q));
    mu_i    = mu_of(q);
    cur_exp = ref_of(op, a, b, q);
    case (op)
      1:       cur_tag = "R3";
      2:       cur_tag = "R4";
      3:       cur_tag = "R5";
      default: cur_tag = "R1";
    endcase
  endtask

  // Called just after a falling edge with inputs driven; records both
  // handshakes that will complete at the coming rising edge.
  task automatic settle();
    logic [W-1:0] e, qm;
    string        t;
    #1;
    if (out_valid_o && out_ready_i) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", res_o, 0);
      end else begin
        e  = exp_q.pop_front();
        qm = mod_q.pop_front();
        t  = tag_q.pop_front();
        check(res_o == e, t, res_o, e);
        check(res_o < qm, "R2", res_o, qm);
      end
    end
    if (in_valid_i && in_ready_o) begin
      exp_q.push_back(cur_exp);
      mod_q.push_back(q_i);
      tag_q.push_back(cur_tag);
    end
    @(negedge clk);
  endtask

  task automatic drain();
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    for (int k = 0; k < 20 && exp_q.size() != 0; k++) settle();
    check(exp_q.size() == 0, "R6", exp_q.size(), 0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R6: watchdog expired, actual %0d expected %0d", 100000, 0);
    summary();
    $finish;
  end

  longint unsigned primes [3] = '{64'd268435399, 64'd536870909, 64'd1073741789};

  initial begin
    logic [W-1:0] held;
    rst_ni      = 1'b0;
    in_valid_i  = 1'b0;
    out_ready_i = 1'b0;
    put(0, 0, 0, 3);
    void'($urandom(7));
    repeat (3) @(negedge clk);

    // R9: reset state
    check(out_valid_o == 1'b0, "R9", out_valid_o, 0);
    check(in_ready_o == 1'b0, "R9", in_ready_o, 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk);
    check(out_valid_o == 1'b0, "R9", out_valid_o, 0);
    check(in_ready_o == 1'b1, "R9", in_ready_o, 1);

    // Vector table, back to back (R1 R3 R4 R5 R8 R10)
    out_ready_i = 1'b1;
    for (int i = 0; i < NTBL; i++) begin
      put(int'(TBL[i][129:128]), TBL[i][127:96], TBL[i][95:64], TBL[i][63:32]);
      cur_exp = TBL[i][31:0];
      if (i == 0) cur_tag = "R10";
      in_valid_i = 1'b1;
      #1;
      check(in_ready_o == 1'b1, "R8", in_ready_o, 1);
      settle();
    end
    drain();

    // Random operands over three prime sizes with random stalls
    foreach (primes[p]) begin
      for (int k = 0; k < NRND; k++) begin
        put(int'($urandom % 3), $urandom % primes[p], $urandom % primes[p], primes[p]);
        in_valid_i  = ($urandom % 4) != 0;
        out_ready_i = ($urandom % 4) != 0;
        settle();
      end
      drain();
    end

    // R6: latency with an empty pipe
    out_ready_i = 1'b1;
    put(0, 123456, 654321, 268435399);
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    check(out_valid_o == 1'b0, "R6", out_valid_o, 0);
    @(negedge clk);
    check(out_valid_o == 1'b0, "R6", out_valid_o, 0);
    @(negedge clk);
    check(out_valid_o == 1'b1, "R6", out_valid_o, 1);
    check(res_o == cur_exp, "R1", res_o, cur_exp);
    @(negedge clk);

    // R7: stall holds the result and blocks intake
    out_ready_i = 1'b0;
    put(1, 10, 12, 17);
    in_valid_i = 1'b1;
    @(negedge clk);
    in_valid_i = 1'b0;
    repeat (2) @(negedge clk);
    check(out_valid_o == 1'b1, "R7", out_valid_o, 1);
    check(res_o == 32'd5, "R3", res_o, 5);
    held = res_o;
    for (int k = 0; k < 3; k++) begin
      in_valid_i = 1'b1;
      @(negedge clk);
      check(out_valid_o == 1'b1 && res_o == held, "R7", res_o, held);
      check(in_ready_o == 1'b0, "R7", in_ready_o, 0);
    end
    in_valid_i  = 1'b0;
    out_ready_i = 1'b1;
    @(negedge clk);
    check(out_valid_o == 1'b0, "R7", out_valid_o, 0);

    // R9: reset in mid-stream discards in-flight work
    put(0, 7, 9, 17);
    in_valid_i = 1'b1;
    repeat (2) @(negedge clk);
    in_valid_i = 1'b0;
    rst_ni     = 1'b0;
    #1;
    check(out_valid_o == 1'b0, "R9", out_valid_o, 0);
    check(in_ready_o == 1'b0, "R9", in_ready_o, 0);
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid_o == 1'b0, "R9", out_valid_o, 0);
    end

    summary();
    $finish;
  end

endmodule